// File: doc/BRIEF.md
# Pin Interrupt Controller

This block turns a single general-purpose input pin into a sticky interrupt request and drives an active-low interrupt line. A small write port holds a configuration word and an enable word. The configuration word sets the pin direction and picks one of four trigger conditions: low level, high level, falling edge or rising edge. The pin passes through a two-flop synchronizer. A status flag latches each time the selected condition occurs.

Software clears the flag by pulsing the status read strobe. The clear takes effect only when the triggering condition is gone at that moment. A level source that is still active keeps the flag, and with it the interrupt, asserted. Any set of conditions other than "configured as input and enabled" forces the flag to zero. As a result no stale request appears when the interrupt is enabled again.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Interrupts are generated only when the setup field, bits [1:0] of the configuration word at address 0x06, equals 01. The codes 00, 10 and 11 hold the status at 0 and the output at 1.
- R2: The enable bit is bit 0 of the word at address 0x007; 1 enables and 0 disables. Writes to any other address change neither the enable nor the configuration.
- R3: The trigger field is bits [3:2] of the configuration word. The codes are 00 = low level, 01 = high level, 10 = falling edge and 11 = rising edge.
- R4: When the block is armed and the selected condition occurs on the synchronized pin, the status flag (`stat_o`) becomes 1.
- R5: A read strobe clears the status only when the condition is absent in that cycle. In a level mode, a read while the level persists leaves the status at 1.
- R6: In an edge mode, a read clears the status, unless a new edge is detected in the same cycle; in that case the status stays at 1.
- R7: `irq_no` is registered. It equals NOT(status AND enable AND setup==01) one clock after these values, so it is low while an armed status is pending.
- R8: Disabling the interrupt, or moving the setup field away from 01, clears the status. Enabling again does not bring back an earlier event.
- R9: After reset the status, the enable and the configuration are zero, and `irq_no` is 1.
- R10: A pin change that arrives before clock edge k is seen by the status at edge k+2 and by `irq_no` at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous pin input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 4 | Register write data |
| stat_rd_i | input | 1 | Status read strobe, one cycle per read |
| stat_o | output | 1 | Status flag readback |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The main sweep covers every combination of setup code, trigger code and enable bit. Each combination sees the same pin pattern: held low, then raised, then lowered, with a read strobe after each phase. The sweep separates level persistence from edge one-shots, tells rising from falling, and shows that only setup 01 with enable set lets an event through. Directed cases place a read in the exact cycle of a new edge, count the latency from the pin to the status and to the output, disarm and rearm with a pending flag, and write to an unused address.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W = 4;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam logic [1:0] SETUP_INPUT = 2'b01;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h06,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [1:0]        setup_o,
  output trig_e             mode_o,
  output logic              en_o
);
  logic wr_cfg, wr_en_reg;
  assign wr_cfg    = wr_en_i && (wr_addr_i == CFG_ADDR);
  assign wr_en_reg = wr_en_i && (wr_addr_i == EN_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_o <= 2'b00;
      mode_o  <= TRIG_LOW;
      en_o    <= 1'b0;
    end else begin
      if (wr_cfg) begin
        setup_o <= wr_data_i[1:0];
        mode_o  <= trig_e'(wr_data_i[3:2]);
      end
      if (wr_en_reg) en_o <= wr_data_i[0];
    end
  end

  // R2: foreign addresses leave the registers untouched
  a_r2_other_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != CFG_ADDR && wr_addr_i != EN_ADDR)
      |=> ($stable(en_o) && $stable(setup_o) && $stable(mode_o)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_s_i,
  input  trig_e mode_i,
  output logic  cond_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= pin_s_i;
  end

  always_comb begin
    unique case (mode_i)
      TRIG_LOW:  cond_o = !pin_s_i;
      TRIG_HIGH: cond_o = pin_s_i;
      TRIG_FALL: cond_o = prev_q && !pin_s_i;
      TRIG_RISE: cond_o = !prev_q && pin_s_i;
      default:   cond_o = 1'b0;
    endcase
  end

  // R6: an edge condition lasts a single cycle for a steady pin
  a_r6_edge_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o && mode_i[1] && $stable(mode_i)) |=> (!cond_o || $changed(pin_s_i) || $changed(mode_i)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h06,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic              stat_o,
  output logic              irq_no
);
  logic [1:0] setup;
  trig_e      mode;
  logic       en, pin_s, cond, armed;
  logic       stat_q, irq_q;

  gpio_irq_cfg #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .EN_ADDR(EN_ADDR)
  ) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .setup_o(setup), .mode_o(mode), .en_o(en)
  );

  gpio_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  gpio_irq_detect i_detect (
    .clk_i, .rst_ni, .pin_s_i(pin_s), .mode_i(mode), .cond_o(cond)
  );

  assign armed = en && (setup == SETUP_INPUT);

  // set beats read-clear; disarm beats both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_q <= 1'b0;
    else if (!armed)    stat_q <= 1'b0;
    else if (cond)      stat_q <= 1'b1;
    else if (stat_rd_i) stat_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else irq_q <= !(stat_q && armed);
  end

  assign stat_o = stat_q;
  assign irq_no = irq_q;

  a_r4_set_on_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && cond) |=> stat_q);

  a_r5_read_clears_when_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !cond && stat_rd_i) |=> !stat_q);

  a_r6_set_wins_over_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && cond && stat_rd_i) |=> stat_q);

  a_r8_disarm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !stat_q);

  a_r7_idle_output_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q |=> irq_no);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       rd = 1'b0;
  logic       stat, irq_n;
  int         nchk = 0, nerr = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .stat_rd_i(rd),
    .stat_o(stat), .irq_no(irq_n)
  );

  task automatic check(input logic got, input logic exp, input string req);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; pin = 1'b0; wr_en = 1'b0; rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic both(input logic exp, input string req);
    check(stat, exp, req);
    check(irq_n, !exp, req);
  endtask

  initial begin
    // R9: reset state
    do_reset();
    settle(2);
    both(1'b0, "R9 reset");

    // R1 R3 R5 sweep: setup x trigger x enable
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          bit armed;
          armed = (e == 1) && (s == 1);
          do_reset();
          wr(8'h06, {m[1:0], s[1:0]});
          wr(8'h07, {3'b000, e[0]});
          settle(6);
          both(armed && m == 0, "R1/R3 low phase");
          rd_pulse(); settle(3);
          both(armed && m == 0, "R5 read while low");
          @(negedge clk) pin = 1'b1;
          settle(6);
          both(armed && m != 2, "R3/R4 high phase");
          rd_pulse(); settle(3);
          both(armed && m == 1, "R5 read while high");
          @(negedge clk) pin = 1'b0;
          settle(6);
          both(armed && m != 3, "R3/R4 fall phase");
          rd_pulse(); settle(3);
          both(armed && m == 0, "R5 read after fall");
        end
      end
    end

    // R10 R7: latency from pin to status and output
    do_reset();
    wr(8'h06, 4'b1101);
    wr(8'h07, 4'b0001);
    settle(4);
    @(negedge clk) pin = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(stat, 1'b0, "R10 status not yet set");
    @(posedge clk); #1;
    check(stat, 1'b1, "R10 status set at third edge");
    check(irq_n, 1'b1, "R7 output one cycle behind");
    @(posedge clk); #1;
    check(irq_n, 1'b0, "R7 output asserted");

    // R6: read in the same cycle as a new edge
    settle(2);
    @(negedge clk) pin = 1'b0;
    settle(6);
    @(negedge clk) pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    check(stat, 1'b1, "R6 set wins over read");
    settle(3);
    rd_pulse(); settle(3);
    both(1'b0, "R6 edge read clears");

    // R8: disarm clears, rearm brings nothing back
    @(negedge clk) pin = 1'b0;
    settle(4);
    @(negedge clk) pin = 1'b1;
    settle(6);
    both(1'b1, "R8 pending before disable");
    wr(8'h07, 4'b0000);
    settle(3);
    both(1'b0, "R8 disable clears");
    wr(8'h07, 4'b0001);
    settle(4);
    both(1'b0, "R8 no stale on rearm");
    wr(8'h06, 4'b1100);
    settle(2);
    wr(8'h06, 4'b1101);
    settle(4);
    both(1'b0, "R8 setup change clears");

    // R2: write to another address does not enable
    do_reset();
    wr(8'h06, 4'b0101);
    wr(8'h05, 4'b0001);
    @(negedge clk) pin = 1'b1;
    settle(6);
    both(1'b0, "R2 foreign address ignored");
    wr(8'h07, 4'b0001);
    settle(3);
    both(1'b1, "R2 enable at 0x007");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule